// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block carries one complete AUX-channel transaction, native or I2C-over-AUX, read or write, from start to a final status. Each attempt is a single request handed to a frame builder, and the single channel outcome returned for it is then interpreted. The outcome is either a channel-level result (good frame, malformed reply, no reply in time, sink unplugged) or, for a good frame, the reply code. Separate budgets for malformed replies, missing replies, AUX-level defers, I2C-level defers, short reads and write status polls decide whether to try again or to stop with a status.

A read that is acknowledged with fewer bytes than asked continues from the new offset with the remaining length. A partially accepted I2C write, or one that is deferred at the I2C level, is followed by zero-length status requests. For I2C-space transactions the sequencer also closes the bus with a zero-length request that has MOT cleared, either when the transaction is the last of its group or when it failed. Between I2C-space retries it waits a fixed number of cycles. A one-cycle done pulse comes with the final status.

Top module: `aux_txn_seq`

## Requirements
- R1: Request command codes are 1000 (native write) and 1001 (native read). For I2C they are 0000 (write) and 0001 (read), and bit 2 is set when `mot` is set. An I2C status request is 0010, or 0110 with MOT. An I2C request carries `addr[7:1]` as its address. A native request carries `addr` unchanged.
- R2: Channel result codes are 0 = good frame, 1 = malformed, 2 = no reply, 3 = unplugged. Two consecutive no-reply results are retried. The third ends the transaction with status 2 (timeout).
- R3: One malformed result is retried. The second ends the transaction with status 3 (protocol error).
- R4: A good-frame result clears the no-reply and malformed counts, so that non-consecutive failures do not add up.
- R5: Reply code 2 (AUX defer) is retried. The 7th AUX defer of a read ends with status 2, and for a write the limit is the larger of `defer_max` and 6. Reply code 8 (I2C defer) clears the AUX defer count and uses its own budget of the same size.
- R6: A read ACK (reply code 0) with more bytes than remain ends with status 3. A read ACK with fewer bytes re-issues the request with the offset advanced and the length reduced by the count. The second short ACK ends with status 3.
- R7: A write ACK with a nonzero count, or an I2C defer on a write, turns later attempts into status requests of length 0 that keep the MOT setting. The 7th nonzero-count ACK ends with status 2.
- R8: A full ACK ends with status 0. Reply code 1 gives status 1 (NACK), channel result 3 gives status 4, and any other reply code gives status 5. `done` pulses for one cycle with the final status.
- R9: An I2C-space transaction that fails, or has `mot` clear, is followed by one extra request of length 0 with the base read/write code and MOT cleared. A native transaction never sends one.
- R10: A native retry is issued in the cycle after the outcome is taken. An I2C-space retry waits `GAP_CYC` more cycles.
- R11: After reset `busy`, `done` and `req_valid` are 0. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a transaction (ignored while busy) |
| op_write | input | 1 | 1 = write, 0 = read |
| space_i2c | input | 1 | 1 = I2C-over-AUX, 0 = native |
| mot | input | 1 | Not the last transaction of its group |
| addr | input | ADDR_W | Native address, or I2C byte address in bits 7:0 |
| len | input | LEN_W | Byte count |
| defer_max | input | CNT_W-1 | Configured write defer limit |
| req_valid | output | 1 | One-cycle request strobe |
| req_cmd | output | 4 | Request command code |
| req_addr | output | ADDR_W | Request address |
| req_len | output | LEN_W | Request byte count |
| req_off | output | LEN_W | Buffer offset of this request |
| rsp_valid | input | 1 | Outcome strobe for the last request |
| rsp_chan | input | 2 | Channel result code |
| rsp_reply | input | 4 | Reply code |
| rsp_count | input | LEN_W | Data bytes returned |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle final strobe |
| status | output | 3 | Final status code |

## Verification
Each budget is swept by feeding k failing outcomes and then a success, for every k from zero to just past the limit. This shows whether the limit is off by one and which status the failure maps to. The write defer sweep runs with two configured limits, one below 6 and one above, to tell apart the two sides of the maximum. Mixed sequences, such as no-reply outcomes separated by defers, or AUX defers split by an I2C defer, tell a counter that is cleared from one that only accumulates. Request logs are compared for command codes, lengths, offsets, address mapping, the closing stop request and the spacing of retries in cycles.

// File: rtl/aux_seq_pkg.sv
package aux_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_GAP, S_STOP, S_STOPW
  } seq_state_t;

  localparam logic [2:0] ST_OK      = 3'd0;
  localparam logic [2:0] ST_NACK    = 3'd1;
  localparam logic [2:0] ST_TIMEOUT = 3'd2;
  localparam logic [2:0] ST_PROTO   = 3'd3;
  localparam logic [2:0] ST_UNPLUG  = 3'd4;
  localparam logic [2:0] ST_UNKNOWN = 3'd5;

  localparam logic [1:0] CH_GOOD    = 2'd0;
  localparam logic [1:0] CH_BAD     = 2'd1;
  localparam logic [1:0] CH_NOREPLY = 2'd2;
  localparam logic [1:0] CH_UNPLUG  = 2'd3;

  localparam logic [3:0] RP_ACK   = 4'd0;
  localparam logic [3:0] RP_NACK  = 4'd1;
  localparam logic [3:0] RP_ADEF  = 4'd2;
  localparam logic [3:0] RP_IDEF  = 4'd8;

  localparam int NCTR      = 6;
  localparam int CI_BAD    = 0;
  localparam int CI_NOREP  = 1;
  localparam int CI_ADEF   = 2;
  localparam int CI_IDEF   = 3;
  localparam int CI_SHORT  = 4;
  localparam int CI_POLL   = 5;

  localparam int LIM_BAD   = 1;
  localparam int LIM_NOREP = 2;
  localparam int LIM_DEF   = 6;
  localparam int LIM_SHORT = 1;
  localparam int LIM_POLL  = 6;

  function automatic logic [3:0] aux_cmd(logic i2c, logic wr, logic m, logic sreq);
    if (!i2c) return {3'b100, ~wr};
    return {1'b0, m, sreq, ~wr & ~sreq};
  endfunction

  function automatic logic [7:0] defer_limit(logic [7:0] cfg);
    return (cfg > 8'(LIM_DEF)) ? cfg : 8'(LIM_DEF);
  endfunction
endpackage

// File: rtl/aux_retry_ctr.sv
module aux_retry_ctr #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [CNT_W-1:0] limit,
  output logic             over
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (clr)                 cnt <= '0;
    else if (inc && cnt != '1)    cnt <= cnt + 1'b1;
  end

  // true when one more increment would pass the limit
  assign over = ({1'b0, cnt} + 1'b1) > {1'b0, limit};
endmodule

// File: rtl/aux_req_fmt.sv
module aux_req_fmt import aux_seq_pkg::*; #(
  parameter int ADDR_W = 20
) (
  input  logic              i2c,
  input  logic              wr,
  input  logic              mot_in,
  input  logic              sreq,
  input  logic              stop,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [3:0]        cmd,
  output logic [ADDR_W-1:0] addr_out
);
  assign cmd      = stop ? aux_cmd(i2c, wr, 1'b0, 1'b0) : aux_cmd(i2c, wr, mot_in, sreq);
  assign addr_out = i2c ? ADDR_W'(addr_in[7:1]) : addr_in;
endmodule

// File: rtl/aux_txn_seq.sv
module aux_txn_seq import aux_seq_pkg::*; #(
  parameter int ADDR_W  = 20,
  parameter int LEN_W   = 5,
  parameter int CNT_W   = 5,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_write,
  input  logic              space_i2c,
  input  logic              mot,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [CNT_W-2:0]  defer_max,
  output logic              req_valid,
  output logic [3:0]        req_cmd,
  output logic [ADDR_W-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [LEN_W-1:0]  req_off,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_chan,
  input  logic [3:0]        rsp_reply,
  input  logic [LEN_W-1:0]  rsp_count,
  output logic              busy,
  output logic              done,
  output logic [2:0]        status
);
  localparam int GAP_W = (GAP_CYC > 1) ? $clog2(GAP_CYC + 1) : 1;

  seq_state_t        state;
  logic              l_wr, l_i2c, l_mot, sreq;
  logic [ADDR_W-1:0] lat_addr;
  logic [CNT_W-2:0]  l_dmax;
  logic [LEN_W-1:0]  rem, off;
  logic [2:0]        fin_st;
  logic [GAP_W-1:0]  gcnt;

  logic [NCTR-1:0]   ctr_inc, ctr_clr, ctr_over;
  logic [CNT_W-1:0]  lim [NCTR];
  logic              clr_all, st_wait, take;
  logic              fin, adv, to_sreq;
  logic [2:0]        fst;
  logic              stop_phase, noreply_over, bad_over;

  assign clr_all    = (state == S_IDLE) && start;
  assign st_wait    = (state == S_WAIT);
  assign take       = st_wait && rsp_valid;
  assign stop_phase = (state == S_STOP);
  assign busy       = (state != S_IDLE);
  assign req_valid  = (state == S_ISSUE) || stop_phase;
  assign req_len    = (stop_phase || sreq) ? '0 : rem;
  assign req_off    = off;
  assign noreply_over = ctr_over[CI_NOREP];
  assign bad_over     = ctr_over[CI_BAD];

  always_comb begin
    lim[CI_BAD]   = CNT_W'(LIM_BAD);
    lim[CI_NOREP] = CNT_W'(LIM_NOREP);
    lim[CI_SHORT] = CNT_W'(LIM_SHORT);
    lim[CI_POLL]  = CNT_W'(LIM_POLL);
    lim[CI_ADEF]  = l_wr ? CNT_W'(defer_limit(8'(l_dmax))) : CNT_W'(LIM_DEF);
    lim[CI_IDEF]  = lim[CI_ADEF];
  end

  for (genvar i = 0; i < NCTR; i++) begin : g_ctr
    aux_retry_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ctr_clr[i] | clr_all),
      .inc   (ctr_inc[i]),
      .limit (lim[i]),
      .over  (ctr_over[i])
    );
  end

  aux_req_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .i2c      (l_i2c),
    .wr       (l_wr),
    .mot_in   (l_mot),
    .sreq     (sreq),
    .stop     (stop_phase),
    .addr_in  (lat_addr),
    .cmd      (req_cmd),
    .addr_out (req_addr)
  );

  // outcome decision for the response being taken
  always_comb begin
    ctr_inc = '0;
    ctr_clr = '0;
    fin     = 1'b0;
    fst     = ST_OK;
    adv     = 1'b0;
    to_sreq = 1'b0;
    if (take) begin
      case (rsp_chan)
        CH_UNPLUG: begin fin = 1'b1; fst = ST_UNPLUG; end
        CH_NOREPLY: begin
          ctr_inc[CI_NOREP] = 1'b1;
          if (ctr_over[CI_NOREP]) begin fin = 1'b1; fst = ST_TIMEOUT; end
        end
        CH_BAD: begin
          ctr_inc[CI_BAD] = 1'b1;
          if (ctr_over[CI_BAD]) begin fin = 1'b1; fst = ST_PROTO; end
        end
        default: begin
          ctr_clr[CI_NOREP] = 1'b1;
          ctr_clr[CI_BAD]   = 1'b1;
          if (!l_wr && rsp_count > rem) begin
            fin = 1'b1; fst = ST_PROTO;
          end else begin
            case (rsp_reply)
              RP_ACK: begin
                ctr_clr[CI_ADEF] = 1'b1;
                if (l_wr) begin
                  if (rsp_count != '0) begin
                    to_sreq = 1'b1;
                    ctr_inc[CI_POLL] = 1'b1;
                    if (ctr_over[CI_POLL]) begin fin = 1'b1; fst = ST_TIMEOUT; end
                  end else fin = 1'b1;
                end else if (rsp_count < rem) begin
                  adv = 1'b1;
                  ctr_inc[CI_SHORT] = 1'b1;
                  if (ctr_over[CI_SHORT]) begin fin = 1'b1; fst = ST_PROTO; end
                end else fin = 1'b1;
              end
              RP_NACK: begin fin = 1'b1; fst = ST_NACK; end
              RP_ADEF: begin
                ctr_inc[CI_ADEF] = 1'b1;
                if (ctr_over[CI_ADEF]) begin fin = 1'b1; fst = ST_TIMEOUT; end
              end
              RP_IDEF: begin
                ctr_clr[CI_ADEF] = 1'b1;
                ctr_inc[CI_IDEF] = 1'b1;
                to_sreq = l_wr;
                if (ctr_over[CI_IDEF]) begin fin = 1'b1; fst = ST_TIMEOUT; end
              end
              default: begin fin = 1'b1; fst = ST_UNKNOWN; end
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      l_wr     <= 1'b0;
      l_i2c    <= 1'b0;
      l_mot    <= 1'b0;
      sreq     <= 1'b0;
      lat_addr <= '0;
      l_dmax   <= '0;
      rem      <= '0;
      off      <= '0;
      fin_st   <= ST_OK;
      gcnt     <= '0;
      done     <= 1'b0;
      status   <= ST_OK;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          l_wr     <= op_write;
          l_i2c    <= space_i2c;
          l_mot    <= mot;
          lat_addr <= addr;
          l_dmax   <= defer_max;
          rem      <= len;
          off      <= '0;
          sreq     <= 1'b0;
          state    <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (rsp_valid) begin
          if (fin) begin
            fin_st <= fst;
            if (l_i2c && (!l_mot || fst != ST_OK)) state <= S_STOP;
            else begin
              done   <= 1'b1;
              status <= fst;
              state  <= S_IDLE;
            end
          end else begin
            if (adv) begin
              rem <= rem - rsp_count;
              off <= off + rsp_count;
            end
            if (to_sreq) sreq <= 1'b1;
            if (l_i2c && GAP_CYC > 0) begin
              gcnt  <= GAP_W'(GAP_CYC - 1);
              state <= S_GAP;
            end else state <= S_ISSUE;
          end
        end
        S_GAP: begin
          if (gcnt == '0) state <= S_ISSUE;
          else gcnt <= gcnt - 1'b1;
        end
        S_STOP: state <= S_STOPW;
        S_STOPW: if (rsp_valid) begin
          done   <= 1'b1;
          status <= fin_st;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_txn_seq_chk.sv
module aux_txn_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int LEN_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [2:0]        status,
  input logic              req_valid,
  input logic [3:0]        req_cmd,
  input logic [ADDR_W-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic              rsp_valid,
  input logic [1:0]        rsp_chan,
  input logic              st_wait,
  input logic              noreply_over,
  input logic              bad_over,
  input logic [ADDR_W-1:0] lat_addr
);
  logic stop_req;
  assign stop_req = req_valid && req_len == '0 && !req_cmd[3] && !req_cmd[2] && !req_cmd[1];

  assert_sreq_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_cmd[3] && req_cmd[1]) |-> (req_len == '0));

  assert_i2c_addr_7bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_cmd[3]) |-> (req_addr[ADDR_W-1:7] == '0));

  assert_noreply_final_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && rsp_valid && rsp_chan == 2'd2 && noreply_over)
      |=> ((done && status == 3'd2) || stop_req));

  assert_bad_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wait && rsp_valid && rsp_chan == 2'd1 && bad_over)
      |=> ((done && status == 3'd3) || stop_req));

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(lat_addr));
endmodule

bind aux_txn_seq aux_txn_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .busy         (busy),
  .done         (done),
  .status       (status),
  .req_valid    (req_valid),
  .req_cmd      (req_cmd),
  .req_addr     (req_addr),
  .req_len      (req_len),
  .rsp_valid    (rsp_valid),
  .rsp_chan     (rsp_chan),
  .st_wait      (st_wait),
  .noreply_over (noreply_over),
  .bad_over     (bad_over),
  .lat_addr     (lat_addr)
);

// File: tb/aux_txn_seq_bench.sv
`timescale 1ns/1ps
module aux_txn_seq_bench;
  localparam int GAP = 4;

  logic        clk = 0, rst_n = 0;
  logic        start = 0, op_write = 0, space_i2c = 0, mot = 0;
  logic [19:0] addr = '0;
  logic [4:0]  len = '0;
  logic [3:0]  defer_max = '0;
  logic        req_valid;
  logic [3:0]  req_cmd;
  logic [19:0] req_addr;
  logic [4:0]  req_len, req_off;
  logic        rsp_valid = 0;
  logic [1:0]  rsp_chan = '0;
  logic [3:0]  rsp_reply = '0;
  logic [4:0]  rsp_count = '0;
  logic        busy, done;
  logic [2:0]  status;

  always #2.5 clk = ~clk;

  aux_txn_seq u_aux_txn_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_write(op_write),
    .space_i2c(space_i2c), .mot(mot), .addr(addr), .len(len),
    .defer_max(defer_max), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_off(req_off),
    .rsp_valid(rsp_valid), .rsp_chan(rsp_chan), .rsp_reply(rsp_reply),
    .rsp_count(rsp_count), .busy(busy), .done(done), .status(status)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int q_ch[32], q_rp[32], q_ct[32];
  int q_n, q_i;
  int l_cmd[64], l_len[64], l_off[64], l_addr[64], l_cyc[64];
  int n_req, res_st, n_done;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic qclr(); q_n = 0; endtask
  task automatic push(int ch, int rp, int ct);
    q_ch[q_n] = ch; q_rp[q_n] = rp; q_ct[q_n] = ct; q_n++;
  endtask
  task automatic pushn(int k, int ch, int rp, int ct);
    for (int i = 0; i < k; i++) push(ch, rp, ct);
  endtask

  // drives one transaction, acts as the frame builder, logs requests
  task automatic run(bit wr, bit i2c, bit m, int a, int l, int dm, bit inject);
    int pend = 0;
    bit fin = 0;
    q_i = 0; n_req = 0; res_st = -1; n_done = 0;
    op_write = wr; space_i2c = i2c; mot = m;
    addr = 20'(a); len = 5'(l); defer_max = 4'(dm);
    start = 1;
    for (int w = 0; w < 3000 && !fin; w++) begin
      @(negedge clk);
      start = inject && (w == 3);
      addr  = (inject && w == 3) ? 20'(a ^ 20'h00F0F) : 20'(a);
      rsp_valid = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          if (q_i < q_n) begin
            rsp_chan = 2'(q_ch[q_i]); rsp_reply = 4'(q_rp[q_i]); rsp_count = 5'(q_ct[q_i]);
          end else begin
            rsp_chan = 2'd0; rsp_reply = 4'd0; rsp_count = 5'd0;
          end
          q_i++;
          rsp_valid = 1;
        end
      end
      if (req_valid && n_req < 64) begin
        l_cmd[n_req] = int'(req_cmd); l_len[n_req] = int'(req_len);
        l_off[n_req] = int'(req_off); l_addr[n_req] = int'(req_addr);
        l_cyc[n_req] = cyc; n_req++;
        pend = 2;
      end
      if (done) begin fin = 1; res_st = int'(status); n_done++; end
    end
    start = 0;
    if (!fin) chk("watchdog: transaction never completed", 0, 1);
    // quiet period: nothing more must come out
    for (int w = 0; w < 12; w++) begin
      @(negedge clk);
      if (done) n_done++;
      if (req_valid) n_req++;
    end
  endtask

  initial begin
    #(200000 * 5);
    chk("watchdog: global time limit", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset busy", int'(busy), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R11 reset req_valid", int'(req_valid), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R8 R9: native read, full ACK, no stop request
    qclr(); push(0, 0, 4);
    run(0, 0, 0, 'h12345, 4, 0, 0);
    chk("R8 native read status", res_st, 0);
    chk("R9 native read request count", n_req, 1);
    chk("R1 native read cmd", l_cmd[0], 9);
    chk("R1 native addr", l_addr[0], 'h12345);
    chk("R1 native len", l_len[0], 4);
    chk("R8 one done pulse", n_done, 1);

    // R1: native write
    qclr(); push(0, 0, 0);
    run(1, 0, 0, 'h00200, 3, 0, 0);
    chk("R1 native write cmd", l_cmd[0], 8);
    chk("R8 native write status", res_st, 0);

    // R6: short read continues
    qclr(); push(0, 0, 2); push(0, 0, 4);
    run(0, 0, 0, 'h100, 6, 0, 0);
    chk("R6 partial status", res_st, 0);
    chk("R6 partial requests", n_req, 2);
    chk("R6 second len", l_len[1], 4);
    chk("R6 second offset", l_off[1], 2);
    // R6: second short read fails
    qclr(); push(0, 0, 1); push(0, 0, 2);
    run(0, 0, 0, 'h100, 6, 0, 0);
    chk("R6 second short status", res_st, 3);
    chk("R6 second short requests", n_req, 2);
    // R6: overcount
    qclr(); push(0, 0, 4);
    run(0, 0, 0, 'h100, 3, 0, 0);
    chk("R6 overcount status", res_st, 3);

    // R2: no-reply sweep, R10 native spacing
    for (int k = 0; k <= 4; k++) begin
      qclr(); pushn(k, 2, 0, 0); push(0, 0, 2);
      run(0, 0, 0, 'h40, 2, 0, 0);
      chk($sformatf("R2 noreply k=%0d status", k), res_st, (k >= 3) ? 2 : 0);
      chk($sformatf("R2 noreply k=%0d requests", k), n_req, (k >= 3) ? 3 : k + 1);
      if (k == 1) chk("R10 native retry spacing", l_cyc[1] - l_cyc[0], 3);
    end

    // R3: malformed sweep
    for (int k = 0; k <= 3; k++) begin
      qclr(); pushn(k, 1, 0, 0); push(0, 0, 2);
      run(0, 0, 0, 'h40, 2, 0, 0);
      chk($sformatf("R3 malformed k=%0d status", k), res_st, (k >= 2) ? 3 : 0);
      chk($sformatf("R3 malformed k=%0d requests", k), n_req, (k >= 2) ? 2 : k + 1);
    end

    // R4: good frames clear the failure counts
    qclr(); push(2,0,0); push(2,0,0); push(0,2,0); push(2,0,0); push(2,0,0); push(0,0,1);
    run(0, 0, 0, 'h40, 1, 0, 0);
    chk("R4 noreply cleared status", res_st, 0);
    chk("R4 noreply cleared requests", n_req, 6);
    qclr(); push(1,0,0); push(0,2,0); push(1,0,0); push(0,0,1);
    run(0, 0, 0, 'h40, 1, 0, 0);
    chk("R4 malformed cleared status", res_st, 0);

    // R5: read AUX defer sweep
    for (int k = 0; k <= 8; k++) begin
      qclr(); pushn(k, 0, 2, 0); push(0, 0, 1);
      run(0, 0, 0, 'h40, 1, 0, 0);
      chk($sformatf("R5 read defer k=%0d status", k), res_st, (k >= 7) ? 2 : 0);
      chk($sformatf("R5 read defer k=%0d requests", k), n_req, (k >= 7) ? 7 : k + 1);
    end
    // R5: write defer limit is max(defer_max, 6)
    for (int d = 0; d < 2; d++) begin
      int dm = (d == 0) ? 2 : 9;
      int lim = (dm > 6) ? dm : 6;
      for (int k = lim - 1; k <= lim + 2; k++) begin
        qclr(); pushn(k, 0, 2, 0); push(0, 0, 0);
        run(1, 0, 0, 'h40, 1, dm, 0);
        chk($sformatf("R5 write defer dm=%0d k=%0d status", dm, k), res_st, (k > lim) ? 2 : 0);
        chk($sformatf("R5 write defer dm=%0d k=%0d requests", dm, k), n_req, (k > lim) ? lim + 1 : k + 1);
      end
    end
    // R5: I2C defer clears AUX defer count
    qclr(); pushn(6, 0, 2, 0); push(0, 8, 0); pushn(6, 0, 2, 0); push(0, 0, 1);
    run(0, 1, 1, 'hA0, 1, 0, 0);
    chk("R5 split defers status", res_st, 0);
    chk("R5 split defers requests", n_req, 14);
    // R5 R9: I2C defer budget exhausted, stop follows
    qclr(); pushn(7, 0, 8, 0);
    run(0, 1, 1, 'hA0, 1, 0, 0);
    chk("R5 i2c defer limit status", res_st, 2);
    chk("R9 stop after failure requests", n_req, 8);
    chk("R9 stop cmd MOT cleared", l_cmd[7], 1);
    chk("R9 stop len", l_len[7], 0);

    // R8: other outcomes
    qclr(); push(0, 1, 0);
    run(0, 0, 0, 'h40, 1, 0, 0);
    chk("R8 nack status", res_st, 1);
    qclr(); push(3, 0, 0);
    run(0, 0, 0, 'h40, 1, 0, 0);
    chk("R8 unplug status", res_st, 4);
    qclr(); push(0, 4, 0);
    run(0, 0, 0, 'h40, 1, 0, 0);
    chk("R8 unknown reply status", res_st, 5);

    // R1 R9: I2C read, last transaction then middle
    qclr(); push(0, 0, 2);
    run(0, 1, 0, 'hA0, 2, 0, 0);
    chk("R9 i2c last requests", n_req, 2);
    chk("R1 i2c read cmd", l_cmd[0], 1);
    chk("R1 i2c addr shift", l_addr[0], 'h50);
    chk("R9 i2c stop cmd", l_cmd[1], 1);
    chk("R9 i2c stop len", l_len[1], 0);
    qclr(); push(0, 0, 2);
    run(0, 1, 1, 'hA0, 2, 0, 0);
    chk("R9 i2c middle requests", n_req, 1);
    chk("R1 i2c read mot cmd", l_cmd[0], 5);

    // R7: write partial ACK -> status request keeps MOT
    qclr(); push(0, 0, 2); push(0, 0, 0);
    run(1, 1, 1, 'hA0, 3, 0, 0);
    chk("R7 partial write status", res_st, 0);
    chk("R7 partial write requests", n_req, 2);
    chk("R1 i2c write mot cmd", l_cmd[0], 4);
    chk("R1 i2c write len", l_len[0], 3);
    chk("R7 status request mot cmd", l_cmd[1], 6);
    chk("R7 status request len", l_len[1], 0);
    // R7: I2C defer on write, last transaction
    qclr(); push(0, 8, 0); push(0, 0, 0);
    run(1, 1, 0, 'hA0, 3, 0, 0);
    chk("R7 idef write requests", n_req, 3);
    chk("R7 status request cmd", l_cmd[1], 2);
    chk("R9 write stop cmd", l_cmd[2], 0);
    // R7: poll budget
    qclr(); pushn(7, 0, 0, 1);
    run(1, 1, 1, 'hA0, 3, 0, 0);
    chk("R7 poll limit status", res_st, 2);
    chk("R7 poll limit requests", n_req, 8);

    // R10: I2C retry spacing
    qclr(); push(2, 0, 0); push(0, 0, 1);
    run(0, 1, 1, 'hA0, 1, 0, 0);
    chk("R10 i2c retry spacing", l_cyc[1] - l_cyc[0], 3 + GAP);

    // R11: start while busy ignored
    qclr(); push(0, 2, 0); push(0, 0, 1);
    run(0, 0, 0, 'h0ABCD, 1, 0, 1);
    chk("R11 inject status", res_st, 0);
    chk("R11 inject requests", n_req, 2);
    chk("R11 inject addr kept", l_addr[1], 'h0ABCD);
    chk("R11 inject single done", n_done, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule